// File: doc/BRIEF.md
# Interleaved Wagging Stream Buffer

This block is a small first-in first-out buffer for an 8-bit data stream. A producer offers words on a valid/ready input port and a consumer takes them from a valid/ready output port. Instead of keeping every word in one long shift chain or in an addressed memory, the storage is split into parallel banks. Each bank is a two-register ripple chain made of a head and a tail register. A write pointer sends consecutive words to the banks in a fixed round-robin order, and a read pointer visits the banks in the same order. Each bank therefore shifts at only a fraction of the stream rate, and the output still follows the input order.

A parameter sets two banks or four banks, which gives four or eight places. Inside a bank, a pop moves the tail into the head. A new word fills the head when the bank is empty, and the tail otherwise. When a pop and a push hit the same bank in one cycle, both happen. Each bank is a three-state machine:

- BANK_VACANT goes to BANK_ONE on a write.
- BANK_ONE goes to BANK_TWO on a write alone, and back to BANK_VACANT on a read alone. It stays put on a write and read together.
- BANK_TWO goes to BANK_ONE on a read alone, and stays put on a read with a write.

A separate occupancy machine tracks the whole buffer:

- OCC_EMPTY goes to OCC_PARTIAL on a push.
- OCC_PARTIAL goes to OCC_FULL when the count reaches capacity, and to OCC_EMPTY when it reaches zero.
- OCC_FULL goes to OCC_PARTIAL on a pop.

Top module: `wag_stream_buffer`

## Requirements
- R1: A synchronous active-high reset empties the buffer and points both bank pointers at bank 0. After reset, out_valid is 0 and in_ready is 1.
- R2: Words leave in the order they were accepted. While out_valid is 1, out_data shows the oldest word still held. Word k goes to bank k mod NUM_BANKS and is read back from that bank in the same rotation.
- R3: The buffer holds 2*NUM_BANKS words. in_ready is 0 exactly when that many words are held, and is 1 otherwise.
- R4: out_valid is 0 exactly when no word is held. Asserting out_ready while the buffer is empty has no effect.
- R5: A push (in_valid and in_ready) and a pop (out_valid and out_ready) in the same cycle are both carried out. Occupancy stays the same, and both pointers advance.
- R6: A word offered while in_ready is 0 is not stored. Draining a full buffer yields exactly 2*NUM_BANKS words.
- R7: A word accepted into an empty buffer appears on out_data, with out_valid at 1, in the cycle after the accepting clock edge.
- R8: While out_valid is 1 and out_ready is 0, out_data holds its value into the next cycle, even if a push happens.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | DATA_W (8) | Word offered by the producer |
| in_valid | input | 1 | Producer offers in_data |
| in_ready | output | 1 | Buffer can take a word |
| out_data | output | DATA_W (8) | Oldest held word |
| out_valid | output | 1 | out_data holds a word |
| out_ready | input | 1 | Consumer takes out_data |

## Verification
The bench builds two copies side by side on the same stimulus. One uses four banks (eight places) and the other uses two banks (four places), so both values of the bank-count parameter are exercised. The small capacities mean that every 4-cycle pattern of in_valid, crossed with every 4-cycle pattern of out_ready, drives each copy through empty, partial and full. That includes repeated wrap-arounds of both pointers and pushes and pops colliding in one bank. Expected flags and data come from a plain queue model per copy.

// File: rtl/wag_buf_pkg.sv
package wag_buf_pkg;

    typedef enum logic [1:0] {
        BANK_VACANT = 2'd0,
        BANK_ONE    = 2'd1,
        BANK_TWO    = 2'd2
    } bank_state_e;

    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_e;

endpackage

// File: rtl/wag_rr_pointer.sv
module wag_rr_pointer #(
    parameter int NUM_BANKS = 2,
    localparam int PTR_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    output logic [PTR_W-1:0] ptr
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_BANKS - 1);

    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_d;

    always_comb begin
        ptr_d = ptr_q;
        if (advance) begin
            ptr_d = (ptr_q == LAST) ? '0 : ptr_q + PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign ptr = ptr_q;

endmodule

// File: rtl/wag_ripple_bank.sv
module wag_ripple_bank
    import wag_buf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] head,
    output bank_state_e       state
);
    bank_state_e       state_q;
    bank_state_e       state_d;
    logic [DATA_W-1:0] head_q;
    logic [DATA_W-1:0] tail_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BANK_VACANT: begin
                if (wr_en) state_d = BANK_ONE;
            end
            BANK_ONE: begin
                if (wr_en && !rd_en)      state_d = BANK_TWO;
                else if (!wr_en && rd_en) state_d = BANK_VACANT;
            end
            BANK_TWO: begin
                if (rd_en && !wr_en) state_d = BANK_ONE;
            end
            default: state_d = BANK_VACANT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= BANK_VACANT;
        end else begin
            state_q <= state_d;
        end
    end

    // ripple data path: head is the oldest word, tail the younger one
    always_ff @(posedge clk) begin
        unique case (state_q)
            BANK_VACANT: begin
                if (wr_en) head_q <= wr_data;
            end
            BANK_ONE: begin
                if (wr_en && rd_en) head_q <= wr_data;
                else if (wr_en)     tail_q <= wr_data;
            end
            BANK_TWO: begin
                if (rd_en) begin
                    head_q <= tail_q;
                    if (wr_en) tail_q <= wr_data;
                end
            end
            default: ;
        endcase
    end

    assign head  = head_q;
    assign state = state_q;

    // The rotating write pointer never lands on a full bank unless it is also drained.
    assert_bank_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rd_en) |-> (state_q != BANK_TWO));

    // The read pointer never selects a vacant bank.
    assert_bank_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (state_q != BANK_VACANT));

endmodule

// File: rtl/wag_occupancy_fsm.sv
module wag_occupancy_fsm
    import wag_buf_pkg::*;
#(
    parameter int CAPACITY = 4,
    localparam int CNT_W = $clog2(CAPACITY + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic out_valid,
    output logic push,
    output logic pop
);
    localparam logic [CNT_W-1:0] CAP_CNT = CNT_W'(CAPACITY);

    occ_state_e       state_q;
    occ_state_e       state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    assign push = in_valid && in_ready;
    assign pop  = out_valid && out_ready;

    always_comb begin
        cnt_d = cnt_q;
        unique case ({push, pop})
            2'b10:   cnt_d = cnt_q + CNT_W'(1);
            2'b01:   cnt_d = cnt_q - CNT_W'(1);
            default: cnt_d = cnt_q;
        endcase
        if (cnt_d == '0)          state_d = OCC_EMPTY;
        else if (cnt_d == CAP_CNT) state_d = OCC_FULL;
        else                       state_d = OCC_PARTIAL;
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= OCC_EMPTY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs from state
    always_comb begin
        unique case (state_q)
            OCC_EMPTY: begin
                in_ready  = 1'b1;
                out_valid = 1'b0;
            end
            OCC_PARTIAL: begin
                in_ready  = 1'b1;
                out_valid = 1'b1;
            end
            OCC_FULL: begin
                in_ready  = 1'b0;
                out_valid = 1'b1;
            end
            default: begin
                in_ready  = 1'b0;
                out_valid = 1'b0;
            end
        endcase
    end

    assert_full_matches_count_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == OCC_FULL) |-> (cnt_q == CAP_CNT));

    assert_empty_matches_count_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == OCC_EMPTY) |-> (cnt_q == '0));

    assert_pair_keeps_count_R5: assert property (@(posedge clk) disable iff (rst)
        (push && pop) |=> $stable(cnt_q));

endmodule

// File: rtl/wag_stream_buffer.sv
module wag_stream_buffer
    import wag_buf_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready
);
    localparam int CAPACITY = 2 * NUM_BANKS;
    localparam int PTR_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    initial begin
        assert (NUM_BANKS == 2 || NUM_BANKS == 4)
            else $error("wag_stream_buffer: NUM_BANKS must be 2 or 4");
    end

    logic             push;
    logic             pop;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    logic [DATA_W-1:0] bank_head [NUM_BANKS];
    bank_state_e       bank_st   [NUM_BANKS];

    wag_occupancy_fsm #(.CAPACITY(CAPACITY)) u_occ (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .push      (push),
        .pop       (pop)
    );

    wag_rr_pointer #(.NUM_BANKS(NUM_BANKS)) u_wr_ptr (
        .clk     (clk),
        .rst     (rst),
        .advance (push),
        .ptr     (wr_ptr)
    );

    wag_rr_pointer #(.NUM_BANKS(NUM_BANKS)) u_rd_ptr (
        .clk     (clk),
        .rst     (rst),
        .advance (pop),
        .ptr     (rd_ptr)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        wag_ripple_bank #(.DATA_W(DATA_W)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (push && (wr_ptr == PTR_W'(b))),
            .wr_data (in_data),
            .rd_en   (pop && (rd_ptr == PTR_W'(b))),
            .head    (bank_head[b]),
            .state   (bank_st[b])
        );
    end

    assign out_data = bank_head[rd_ptr];

    // A stalled output word must not move, even when a push lands in the same bank.
    assert_stall_holds_data_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> $stable(out_data));

    // The bank under the read pointer holds a word whenever the buffer reports one.
    assert_read_bank_occupied_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (bank_st[rd_ptr] != BANK_VACANT));

endmodule

// File: tb/tb_wag_stream_buffer.sv
module tb_wag_stream_buffer;
    localparam int CAP_A = 8;
    localparam int CAP_B = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       out_ready = 1'b0;

    logic       a_in_ready, a_out_valid, b_in_ready, b_out_valid;
    logic [7:0] a_out_data, b_out_data;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;
    logic [7:0] data_ctr = 8'd1;
    logic [7:0] qa[$];
    logic [7:0] qb[$];
    int pops_a = 0;
    int pops_b = 0;

    always #2 clk = ~clk;

    wag_stream_buffer #(.NUM_BANKS(4), .DATA_W(8)) dut (
        .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
        .in_ready(a_in_ready), .out_data(a_out_data), .out_valid(a_out_valid),
        .out_ready(out_ready)
    );

    wag_stream_buffer #(.NUM_BANKS(2), .DATA_W(8)) dut_b2 (
        .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
        .in_ready(b_in_ready), .out_data(b_out_data), .out_valid(b_out_valid),
        .out_ready(out_ready)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, check flags and data against the queue models.
    task automatic drive(input bit iv, input bit ordy);
        bit a_in, a_out, b_in, b_out;
        in_valid  = iv;
        in_data   = data_ctr;
        out_ready = ordy;
        #1;
        chk(a_in_ready == (qa.size() < CAP_A), "R3 A in_ready", int'(a_in_ready), int'(qa.size() < CAP_A));
        chk(a_out_valid == (qa.size() > 0), "R4 A out_valid", int'(a_out_valid), int'(qa.size() > 0));
        if (qa.size() > 0) chk(a_out_data == qa[0], "R2 A out_data", int'(a_out_data), int'(qa[0]));
        chk(b_in_ready == (qb.size() < CAP_B), "R3 B in_ready", int'(b_in_ready), int'(qb.size() < CAP_B));
        chk(b_out_valid == (qb.size() > 0), "R4 B out_valid", int'(b_out_valid), int'(qb.size() > 0));
        if (qb.size() > 0) chk(b_out_data == qb[0], "R2 B out_data", int'(b_out_data), int'(qb[0]));
        a_in  = iv && (qa.size() < CAP_A);
        a_out = ordy && (qa.size() > 0);
        b_in  = iv && (qb.size() < CAP_B);
        b_out = ordy && (qb.size() > 0);
        if (a_out) begin void'(qa.pop_front()); pops_a++; end
        if (a_in) qa.push_back(data_ctr);
        if (b_out) begin void'(qb.pop_front()); pops_b++; end
        if (b_in) qb.push_back(data_ctr);
        if (iv) data_ctr = data_ctr + 8'd1;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        out_ready = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        qa.delete();
        qb.delete();
        #1;
        chk(!a_out_valid && a_in_ready, "R1 A reset flags", int'({a_out_valid, a_in_ready}), 1);
        chk(!b_out_valid && b_in_ready, "R1 B reset flags", int'({b_out_valid, b_in_ready}), 1);
    endtask

    initial begin
        int cycles = 0;
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                nerr++;
                nchk++;
                $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
                $display("Result: errors=%0d of %0d checks", nerr, nchk);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] held;
        @(negedge clk);
        do_reset();

        // R4: out_ready on empty buffer has no effect
        drive(1'b0, 1'b1);
        drive(1'b0, 1'b1);
        chk(!a_out_valid && pops_a == 0, "R4 A pop on empty", pops_a, 0);

        // R7: single word visible next cycle
        held = data_ctr;
        drive(1'b1, 1'b0);
        chk(a_out_valid && a_out_data == held, "R7 A first word", int'(a_out_data), int'(held));
        chk(b_out_valid && b_out_data == held, "R7 B first word", int'(b_out_data), int'(held));

        // R8: stall with pushes, head word held
        for (int k = 0; k < 3; k++) begin
            drive(1'b1, 1'b0);
            chk(a_out_data == held, "R8 A stalled data", int'(a_out_data), int'(held));
            chk(b_out_data == held, "R8 B stalled data", int'(b_out_data), int'(held));
        end

        // R6: fill past capacity, extra offers ignored
        for (int k = 0; k < CAP_A + 4; k++) drive(1'b1, 1'b0);
        chk(!a_in_ready, "R3 A full", int'(a_in_ready), 0);
        chk(!b_in_ready, "R3 B full", int'(b_in_ready), 0);
        pops_a = 0;
        pops_b = 0;
        for (int k = 0; k < CAP_A + 3; k++) drive(1'b0, 1'b1);
        chk(pops_a == CAP_A, "R6 A drained count", pops_a, CAP_A);
        chk(pops_b == CAP_B, "R6 B drained count", pops_b, CAP_B);
        chk(!a_out_valid && !b_out_valid, "R4 empty after drain", int'({a_out_valid, b_out_valid}), 0);

        // R5: push and pop together keep one word in flight
        drive(1'b1, 1'b0);
        for (int k = 0; k < 12; k++) begin
            held = data_ctr;
            drive(1'b1, 1'b1);
            chk(a_out_valid && a_in_ready && a_out_data == held, "R5 A pair", int'(a_out_data), int'(held));
            chk(b_out_valid && b_in_ready && b_out_data == held, "R5 B pair", int'(b_out_data), int'(held));
        end

        // R5: push and pop together while full
        for (int k = 0; k < CAP_A; k++) drive(1'b1, 1'b0);
        for (int k = 0; k < 6; k++) drive(1'b1, 1'b1);

        // Sweep every 4-cycle valid pattern against every 4-cycle ready pattern (R2 R3 R4).
        for (int pv = 0; pv < 16; pv++) begin
            for (int pr = 0; pr < 16; pr++) begin
                for (int k = 0; k < 40; k++) begin
                    drive(pv[k % 4], pr[k % 4]);
                end
            end
        end

        // R1: reset from a non-empty state
        for (int k = 0; k < 5; k++) drive(1'b1, 1'b0);
        do_reset();
        drive(1'b0, 1'b1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule